// File: doc/BRIEF.md
# Multi-Channel Logic Capture Front-End

The block watches a 24-bit probe bus, split into three byte-wide channel groups, and records a short burst of bytes into an internal buffer. A one-cycle `start` pulse arms a burst. A divider then produces a sampling tick every `tick_div + 1` clock cycles. Ticks alternate between two phases. On a grab tick one group is latched. On the following store tick that byte is written into the buffer. The fastest byte rate is therefore half the tick rate. With `tick_div = 3` the tick is a quarter of the system clock, and the burst rate is one eighth of it.

Groups are taken in the order 0, 1, 2. All 24 probe bits are snapshotted when group 0 is grabbed, so each triple of bytes comes from one moment in time. Capture stops once the buffer holds 16 bytes. The stored bytes then leave in write order through a byte-wide valid/ready port that feeds a serial transmitter. `busy` covers the whole span from the accepted start pulse to the handshake of the last byte.

Top module: `logic_capture_fe`

## Requirements
- R1: After synchronous reset, `busy` and `out_valid` are 0.
- R2: A `start` pulse seen while `busy` is 0 makes `busy` read 1 on the following cycle.
- R3: A burst delivers exactly DEPTH (16) bytes on the output port, and `busy` stays 1 until all of them have been accepted.
- R4: Byte k of a burst carries probe bits [8*(k mod 3)+7 : 8*(k mod 3)] of the snapshot that belongs to byte k - (k mod 3).
- R5: Ticks occur every `tick_div + 1` cycles, counted from the cycle in which start is accepted. The snapshot for byte j is taken at tick 2j+1 (the grab tick), and byte j is written at tick 2j+2. `out_valid` first rises on the clock edge after the last store tick, which is edge 32*(tick_div+1)+1 counted from the start edge.
- R6: Bytes leave in write order. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R7: `busy` and `out_valid` drop together on the clock edge that accepts the last byte. `out_valid` is never 1 while `busy` is 0.
- R8: A `start` pulse that arrives while `busy` is 1 has no effect on the capture, the byte count or the output timing.
- R9: A reset in the middle of capture or of draining empties the buffer and clears the group index. The next burst starts again at group 0 with fresh data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that arms a burst when idle |
| tick_div | input | 8 | Tick period minus one, in clock cycles |
| probe_in | input | 24 | Probe bus, three 8-bit groups |
| out_ready | input | 1 | Serial stage accepts the current byte |
| out_data | output | 8 | Buffered byte to transmit |
| out_valid | output | 1 | `out_data` holds a byte |
| busy | output | 1 | Burst in progress (capture or drain) |

## Verification
If the group index or the snapshot register goes wrong, the bytes come out of their group or from the wrong instant. This shows in the first drained triple, because every byte is compared with the probe history recorded per cycle. An error in the write pointer or the phase bit moves the cycle in which `out_valid` first rises, or changes the number of bytes before `busy` falls. Both are caught within one burst. Read-side faults show at once as reordered bytes or as data that changes during a stall.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAP   = 2'd1,
    ST_DRAIN = 2'd2
  } cap_state_e;
endpackage

// File: rtl/lc_rate_div.sv
module lc_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en) cnt <= (cnt == div) ? '0 : cnt + 1'b1;
  end

  // R5: the counter never runs past the programmed limit while enabled
  p_cnt_limit_r5: assert property (@(posedge clk) disable iff (rst)
    en && $stable(div) && (cnt <= div) |=> (cnt <= div) || clr || !en);
endmodule

// File: rtl/lc_group_sel.sv
module lc_group_sel #(
  parameter int GRP_W = 8,
  parameter int N_GRP = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   grab,
  input  logic                   adv,
  input  logic [N_GRP*GRP_W-1:0] probe,
  output logic [GRP_W-1:0]       hold
);
  localparam int IDX_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_GRP - 1);

  logic [IDX_W-1:0]       grp;
  logic [N_GRP*GRP_W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp  <= '0;
      snap <= '0;
      hold <= '0;
    end else begin
      if (clr) grp <= '0;
      else if (adv) grp <= (grp == LAST) ? '0 : grp + 1'b1;
      if (grab) begin
        if (grp == '0) begin
          snap <= probe;
          hold <= probe[GRP_W-1:0];
        end else begin
          hold <= snap[grp*GRP_W +: GRP_W];
        end
      end
    end
  end

  p_grp_range_r4: assert property (@(posedge clk) disable iff (rst)
    grp <= LAST);
  // R9: a clear always returns selection to group 0
  p_clr_group_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> grp == '0);
endmodule

// File: rtl/lc_burst_buf.sv
module lc_burst_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[raddr];
  end
endmodule

// File: rtl/logic_capture_fe.sv
module logic_capture_fe
  import lc_pkg::*;
#(
  parameter int GRP_W = 8,
  parameter int N_GRP = 3,
  parameter int DEPTH = 16,
  parameter int DIV_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [DIV_W-1:0]       tick_div,
  input  logic [N_GRP*GRP_W-1:0] probe_in,
  input  logic                   out_ready,
  output logic [GRP_W-1:0]       out_data,
  output logic                   out_valid,
  output logic                   busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST_W = CW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);

  cap_state_e      state;
  logic            store_ph;
  logic [CW-1:0]   wptr;
  logic [CW-1:0]   rptr;
  logic            tick;
  logic            start_acc, grab, wr_en, rd_en;
  logic [GRP_W-1:0] hold;

  assign start_acc = start && (state == ST_IDLE);
  assign grab      = (state == ST_CAP) && tick && !store_ph;
  assign wr_en     = (state == ST_CAP) && tick && store_ph;
  assign rd_en     = (state == ST_DRAIN) && (!out_valid || out_ready) && (rptr != FULL);
  assign busy      = (state != ST_IDLE);

  lc_rate_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .clr(start_acc), .en(state == ST_CAP),
    .div(tick_div), .tick(tick)
  );

  lc_group_sel #(.GRP_W(GRP_W), .N_GRP(N_GRP)) grp_i (
    .clk(clk), .rst(rst), .clr(start_acc), .grab(grab), .adv(wr_en),
    .probe(probe_in), .hold(hold)
  );

  lc_burst_buf #(.W(GRP_W), .DEPTH(DEPTH)) buf_i (
    .clk(clk), .wr_en(wr_en), .waddr(wptr[AW-1:0]), .wdata(hold),
    .rd_en(rd_en), .raddr(rptr[AW-1:0]), .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      store_ph  <= 1'b0;
      wptr      <= '0;
      rptr      <= '0;
      out_valid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_CAP;
            store_ph <= 1'b0;
            wptr     <= '0;
          end
        end
        ST_CAP: begin
          if (tick) begin
            store_ph <= !store_ph;
            if (store_ph) begin
              wptr <= wptr + 1'b1;
              if (wptr == LAST_W) begin
                state <= ST_DRAIN;
                rptr  <= '0;
              end
            end
          end
        end
        ST_DRAIN: begin
          if (rd_en) begin
            rptr      <= rptr + 1'b1;
            out_valid <= 1'b1;
          end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_wptr_bound_r3: assert property (@(posedge clk) disable iff (rst)
    wptr <= FULL);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_valid_busy_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    start && (state == ST_CAP) |=> (state != ST_IDLE) && (wptr >= $past(wptr)));
  p_drain_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    start && (state == ST_DRAIN) |=> state != ST_CAP);
endmodule

// File: tb/logic_capture_fe_tb_top.sv
module logic_capture_fe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  tick_div = 8'd0;
  logic [23:0] probe_in = '0;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] hist [0:511];
  logic [7:0]  got  [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_capture_fe dut_i (
    .clk(clk), .rst(rst), .start(start), .tick_div(tick_div),
    .probe_in(probe_in), .out_ready(out_ready), .out_data(out_data),
    .out_valid(out_valid), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k, input int d);
    int base = k - (k % 3);
    int m = (2 * base + 1) * (d + 1);
    logic [23:0] s = hist[m];
    return s[8*(k%3) +: 8];
  endfunction

  task automatic run_burst(input int d, input int rdy_pct, input bit poke);
    int n = 0;
    int first_v = -1;
    int got_n = 0;
    bit prev_stall = 0;
    logic [7:0] prev_data = '0;
    bit done = 0;
    bit ready;
    @(negedge clk);
    tick_div = 8'(d);
    start = 1'b1;
    probe_in = 24'($urandom);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    while (!done) begin
      if (out_valid && first_v < 0) first_v = n;
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R6", "stall hold data",
            int'(out_data), int'(prev_data));
      chk(out_valid ? busy : 1'b1, "R7", "valid without busy", int'(busy), 1);
      ready = ($urandom % 100) < rdy_pct;
      out_ready = ready;
      if (out_valid && ready) begin
        if (got_n < 32) got[got_n] = out_data;
        got_n++;
      end
      prev_stall = out_valid && !ready;
      prev_data = out_data;
      probe_in = 24'($urandom);
      if (n + 1 < 512) hist[n+1] = probe_in;
      start = poke && (n == 7 || (out_valid && got_n == 5));
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (got_n >= DEPTH) begin
        chk(!busy && !out_valid, "R7", "busy/valid after last byte",
            int'(busy) * 2 + int'(out_valid), 0);
        done = 1;
      end else if (!busy) begin
        chk(0, "R3", "burst ended early, bytes", got_n, DEPTH);
        done = 1;
      end else if (n > 4000) begin
        chk(0, "R3", "burst never finished, bytes", got_n, DEPTH);
        done = 1;
      end
    end
    out_ready = 1'b0;
    chk(got_n == DEPTH, "R3", "bytes per burst", got_n, DEPTH);
    chk(first_v == 32 * (d + 1) + 1, "R5", "first valid cycle", first_v, 32 * (d + 1) + 1);
    for (int k = 0; k < DEPTH && k < got_n; k++)
      chk(got[k] == exp_byte(k, d), "R4", $sformatf("byte %0d", k),
          int'(got[k]), int'(exp_byte(k, d)));
    if (poke)
      chk(got_n == DEPTH && first_v == 32 * (d + 1) + 1, "R8",
          "start while busy changed burst", first_v, 32 * (d + 1) + 1);
  endtask

  task automatic reset_during(input int d, input int wait_cyc, input bit in_drain);
    @(negedge clk);
    tick_div = 8'(d);
    start = 1'b1;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (wait_cyc) @(negedge clk);
    if (in_drain)
      chk(out_valid == 1'b1, "R6", "valid held during stall", int'(out_valid), 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !out_valid, "R9", "state after mid-burst reset",
        int'(busy) * 2 + int'(out_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !out_valid, "R1", "reset state",
        int'(busy) * 2 + int'(out_valid), 0);

    run_burst(0, 100, 0);
    run_burst(3, 100, 1);
    run_burst(1, 30, 0);
    reset_during(2, 25, 0);
    run_burst(2, 60, 0);
    reset_during(0, 40, 1);
    run_burst(0, 50, 1);
    for (int i = 0; i < 6; i++)
      run_burst(int'($urandom % 6), 20 + int'($urandom % 81), bit'($urandom % 2));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule